// File: doc/BRIEF.md
# Ethernet PHY Management Register File

This block holds the management registers of a simple 10/100 Ethernet PHY, the set a MAC reaches through its management read and write registers. An access carries a PHY address, a 5-bit register index and, for writes, 16-bit data with a write strobe. Reads use a read strobe and return 16-bit data combinationally from the current register state.

The register set has six members. Control and advertisement are writable. Status and link-partner ability follow a link-up input. Two identifier words are fixed by parameters. Every other index reads as zero.

Setting the top bit of a control write resets the register set in place. An access aimed at another PHY address floats high on reads and has no effect on writes.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After reset, control (index 0) reads 0x3100 and advertisement (index 4) reads 0x01E1.
- R2: One clock edge after link_up is sampled high, status (index 1) reads 0x786C (bit 2 link, bit 5 negotiation done) and partner ability (index 5) reads 0x01E1. Before that edge the old values are still returned.
- R3: One clock edge after link_up is sampled low, status reads 0x7848 and partner ability reads 0x0080.
- R4: A read whose acc_addr differs from parameter PHY_ADDR returns 0xFFFF. A write to such an address changes no register.
- R5: A write to control with bit 15 clear stores the written value verbatim.
- R6: A write to control with bit 15 set returns control and advertisement to their R1 values and does not store the written value. Status and partner ability keep reflecting the current link state.
- R7: A write to advertisement stores the written value verbatim.
- R8: Writes to status, both identifier words, partner ability and expansion (index 6) are dropped.
- R9: Reads of expansion (index 6) and of every index from 7 to 31 return 0.
- R10: Index 2 reads parameter ID_WORD1 and index 3 reads parameter ID_WORD2.
- R11: rd_data is 0 while rd_en is low. A read in the same cycle as a write to the same register returns the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | ADDR_W | PHY address of the access |
| acc_reg | input | IDX_W | Register index of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read strobe |
| link_up | input | 1 | Current link state |
| rd_data | output | DW | Read data, combinational |

## Verification
The bench builds the block with PHY_ADDR set to 3 and identifier words 0xA5C3 and 0x0F1E, so none of them equals a reset value or zero. Addresses 0 and 31 therefore act as foreign PHYs. This lets the bench tell a correct address match apart from a hard-wired default. It also catches an identifier mux that returns the wrong word. With link_up driven from the bench, the one-edge lag of status and partner ability can be observed by reading just before and just after the edge.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int unsigned DW_DEF = 16;

  localparam int unsigned IDX_CTRL    = 0;
  localparam int unsigned IDX_STAT    = 1;
  localparam int unsigned IDX_ID1     = 2;
  localparam int unsigned IDX_ID2     = 3;
  localparam int unsigned IDX_ADV     = 4;
  localparam int unsigned IDX_PARTNER = 5;

  localparam int unsigned CTRL_SOFT_RESET_BIT = 15;

  // control: 100 Mb/s select (13), autoneg enable (12), full duplex (8)
  localparam logic [15:0] CTRL_INIT       = 16'h3100;
  // status: four speed/duplex abilities, preamble suppression, autoneg ability
  localparam logic [15:0] STAT_FIXED      = 16'h7848;
  // status: link (2) and autoneg complete (5)
  localparam logic [15:0] STAT_LINK_MASK  = 16'h0024;
  localparam logic [15:0] ADV_INIT        = 16'h01E1;
  localparam logic [15:0] PARTNER_DOWN    = 16'h0080;
  localparam logic [15:0] PARTNER_UP_ADD  = 16'h0161;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_STAT, SEL_ID1, SEL_ID2, SEL_ADV, SEL_PARTNER
  } reg_sel_e;

  typedef struct packed {
    logic     hit;
    reg_sel_e sel;
  } decode_t;
endpackage

// File: rtl/phy_mgmt_decode.sv
module phy_mgmt_decode
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned IDX_W  = 5,
  parameter logic [ADDR_W-1:0] PHY_ADDR = '0
) (
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [IDX_W-1:0]  acc_reg,
  output decode_t           dec
);
  always_comb begin
    dec.hit = (acc_addr == PHY_ADDR);
    case (int'(acc_reg))
      IDX_CTRL:    dec.sel = SEL_CTRL;
      IDX_STAT:    dec.sel = SEL_STAT;
      IDX_ID1:     dec.sel = SEL_ID1;
      IDX_ID2:     dec.sel = SEL_ID2;
      IDX_ADV:     dec.sel = SEL_ADV;
      IDX_PARTNER: dec.sel = SEL_PARTNER;
      default:     dec.sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/phy_mgmt_ctrl_regs.sv
module phy_mgmt_ctrl_regs
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned DW = DW_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctrl,
  input  logic          wr_adv,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] adv_q
);
  logic soft_reset;
  assign soft_reset = wr_ctrl && wr_data[CTRL_SOFT_RESET_BIT];

  always_ff @(posedge clk) begin
    if (rst || soft_reset) begin
      ctrl_q <= DW'(CTRL_INIT);
      adv_q  <= DW'(ADV_INIT);
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data;
      if (wr_adv)  adv_q  <= wr_data;
    end
  end
endmodule

// File: rtl/phy_mgmt_link_state.sv
module phy_mgmt_link_state
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned DW = DW_DEF
) (
  input  logic          clk,
  input  logic          link_up,
  output logic [DW-1:0] status_q,
  output logic [DW-1:0] partner_q
);
  // Sampled every cycle, during reset too, so a reset always picks up the live link
  always_ff @(posedge clk) begin
    status_q  <= DW'(STAT_FIXED | (link_up ? STAT_LINK_MASK : 16'h0000));
    partner_q <= DW'(PARTNER_DOWN | (link_up ? PARTNER_UP_ADD : 16'h0000));
  end
endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned DW     = DW_DEF,
  parameter logic [ADDR_W-1:0] PHY_ADDR = '0,
  parameter logic [DW-1:0] ID_WORD1 = 16'h1234,
  parameter logic [DW-1:0] ID_WORD2 = 16'h5A60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [IDX_W-1:0]  acc_reg,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic              link_up,
  output logic [DW-1:0]     rd_data
);
  localparam logic [DW-1:0] FLOAT_HIGH = {DW{1'b1}};

  decode_t       dec;
  logic          wr_ctrl, wr_adv;
  logic [DW-1:0] ctrl_q, adv_q, status_q, partner_q;

  phy_mgmt_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PHY_ADDR(PHY_ADDR)) u_dec (
    .acc_addr(acc_addr), .acc_reg(acc_reg), .dec(dec)
  );

  assign wr_ctrl = wr_en && dec.hit && (dec.sel == SEL_CTRL);
  assign wr_adv  = wr_en && dec.hit && (dec.sel == SEL_ADV);

  phy_mgmt_ctrl_regs #(.DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_adv(wr_adv),
    .wr_data(wr_data), .ctrl_q(ctrl_q), .adv_q(adv_q)
  );

  phy_mgmt_link_state #(.DW(DW)) u_link (
    .clk(clk), .link_up(link_up), .status_q(status_q), .partner_q(partner_q)
  );

  always_comb begin
    if (!rd_en)        rd_data = '0;
    else if (!dec.hit) rd_data = FLOAT_HIGH;
    else begin
      case (dec.sel)
        SEL_CTRL:    rd_data = ctrl_q;
        SEL_STAT:    rd_data = status_q;
        SEL_ID1:     rd_data = ID_WORD1;
        SEL_ID2:     rd_data = ID_WORD2;
        SEL_ADV:     rd_data = adv_q;
        SEL_PARTNER: rd_data = partner_q;
        default:     rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/phy_mgmt_regfile_chk.sv
module phy_mgmt_regfile_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned DW     = 16,
  parameter logic [ADDR_W-1:0] PHY_ADDR = '0,
  parameter logic [DW-1:0] ID_WORD1 = '0,
  parameter logic [DW-1:0] ID_WORD2 = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [IDX_W-1:0]  acc_reg,
  input logic              wr_en,
  input logic [DW-1:0]     wr_data,
  input logic              rd_en,
  input logic              link_up,
  input logic [DW-1:0]     rd_data,
  input logic [DW-1:0]     ctrl_q,
  input logic [DW-1:0]     adv_q
);
  logic mine;
  assign mine = (acc_addr == PHY_ADDR);

  p_foreign_read_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mine) |-> rd_data == {DW{1'b1}});
  p_foreign_write_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !mine) |=> ($stable(ctrl_q) && $stable(adv_q)));
  p_link_status_r2: assert property (@(posedge clk) disable iff (rst)
    link_up |=> (!(rd_en && mine && acc_reg == IDX_W'(1)) || (rd_data[2] && rd_data[5])));
  p_link_partner_r3: assert property (@(posedge clk) disable iff (rst)
    !link_up |=> (!(rd_en && mine && acc_reg == IDX_W'(5)) || rd_data == DW'(16'h0080)));
  p_ctrl_store_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mine && acc_reg == IDX_W'(0) && !wr_data[15]) |=> ctrl_q == $past(wr_data));
  p_soft_reset_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mine && acc_reg == IDX_W'(0) && wr_data[15])
      |=> (ctrl_q == DW'(16'h3100) && adv_q == DW'(16'h01E1)));
  p_adv_store_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mine && acc_reg == IDX_W'(4)) |=> adv_q == $past(wr_data));
  p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && mine && acc_reg >= IDX_W'(6)) |-> rd_data == '0);
  p_ident_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && mine && acc_reg == IDX_W'(2)) |-> rd_data == ID_WORD1);
  p_idle_read_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> rd_data == '0);
endmodule

bind phy_mgmt_regfile phy_mgmt_regfile_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DW(DW), .PHY_ADDR(PHY_ADDR),
  .ID_WORD1(ID_WORD1), .ID_WORD2(ID_WORD2)
) u_chk (
  .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_reg(acc_reg),
  .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .link_up(link_up),
  .rd_data(rd_data), .ctrl_q(ctrl_q), .adv_q(adv_q)
);

// File: tb/phy_mgmt_regfile_bench.sv
module phy_mgmt_regfile_bench;
  localparam int CLK_P = 10;
  localparam logic [4:0] ME = 5'd3;
  localparam logic [15:0] ID1 = 16'hA5C3;
  localparam logic [15:0] ID2 = 16'h0F1E;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] acc_addr = '0;
  logic [4:0] acc_reg = '0;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic link_up = 1'b0;
  logic [15:0] rd_data;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  phy_mgmt_regfile #(.PHY_ADDR(ME), .ID_WORD1(ID1), .ID_WORD2(ID2)) u_phy_mgmt_regfile (
    .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_reg(acc_reg),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .link_up(link_up),
    .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, input logic [4:0] r, output logic [15:0] v);
    @(negedge clk);
    acc_addr = a; acc_reg = r; rd_en = 1'b1;
    #1 v = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [4:0] r, input logic [15:0] d);
    @(negedge clk);
    acc_addr = a; acc_reg = r; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset_values;
    logic [15:0] v;
    rd(ME, 5'd0, v); chk("R1 control reset", v, 16'h3100);
    rd(ME, 5'd4, v); chk("R1 advert reset", v, 16'h01E1);
    rd(ME, 5'd1, v); chk("R3 status link down", v, 16'h7848);
    rd(ME, 5'd5, v); chk("R3 partner link down", v, 16'h0080);
    rd(ME, 5'd2, v); chk("R10 id word 1", v, ID1);
    rd(ME, 5'd3, v); chk("R10 id word 2", v, ID2);
  endtask

  task automatic t_link;
    logic [15:0] v;
    @(negedge clk);
    link_up = 1'b1; acc_addr = ME; acc_reg = 5'd1; rd_en = 1'b1;
    #1 chk("R2 status before edge", rd_data, 16'h7848);
    @(negedge clk);
    #1 chk("R2 status after edge", rd_data, 16'h786C);
    rd_en = 1'b0;
    rd(ME, 5'd5, v); chk("R2 partner link up", v, 16'h01E1);
    @(negedge clk); link_up = 1'b0;
    rd(ME, 5'd1, v); chk("R3 status after drop", v, 16'h7848);
    rd(ME, 5'd5, v); chk("R3 partner after drop", v, 16'h0080);
  endtask

  task automatic t_writable;
    logic [15:0] v;
    wr(ME, 5'd0, 16'h1200); rd(ME, 5'd0, v); chk("R5 control stored", v, 16'h1200);
    wr(ME, 5'd4, 16'h0061); rd(ME, 5'd4, v); chk("R7 advert stored", v, 16'h0061);
  endtask

  task automatic t_soft_reset;
    logic [15:0] v;
    @(negedge clk); link_up = 1'b1;
    wr(ME, 5'd0, 16'h8000);
    rd(ME, 5'd0, v); chk("R6 control after soft reset", v, 16'h3100);
    rd(ME, 5'd4, v); chk("R6 advert after soft reset", v, 16'h01E1);
    rd(ME, 5'd1, v); chk("R6 status keeps link", v, 16'h786C);
    wr(ME, 5'd4, 16'h0041);
    wr(ME, 5'd0, 16'hFFFF);
    rd(ME, 5'd0, v); chk("R6 value not stored", v, 16'h3100);
    rd(ME, 5'd4, v); chk("R6 advert reset again", v, 16'h01E1);
    @(negedge clk); link_up = 1'b0;
  endtask

  task automatic t_read_only;
    logic [15:0] v;
    wr(ME, 5'd1, 16'h0000); rd(ME, 5'd1, v); chk("R8 status write dropped", v, 16'h7848);
    wr(ME, 5'd2, 16'h0000); rd(ME, 5'd2, v); chk("R8 id1 write dropped", v, ID1);
    wr(ME, 5'd3, 16'hFFFF); rd(ME, 5'd3, v); chk("R8 id2 write dropped", v, ID2);
    wr(ME, 5'd5, 16'hFFFF); rd(ME, 5'd5, v); chk("R8 partner write dropped", v, 16'h0080);
    wr(ME, 5'd6, 16'hFFFF); rd(ME, 5'd6, v); chk("R8 expansion write dropped", v, 16'h0000);
    rd(ME, 5'd0, v); chk("R8 control untouched", v, 16'h3100);
    rd(ME, 5'd4, v); chk("R8 advert untouched", v, 16'h01E1);
  endtask

  task automatic t_unmapped;
    logic [15:0] v;
    rd(ME, 5'd7, v);  chk("R9 index 7", v, 16'h0000);
    rd(ME, 5'd10, v); chk("R9 index 10", v, 16'h0000);
    rd(ME, 5'd16, v); chk("R9 index 16", v, 16'h0000);
    rd(ME, 5'd31, v); chk("R9 index 31", v, 16'h0000);
  endtask

  task automatic t_foreign;
    logic [15:0] v;
    rd(5'd0, 5'd0, v);  chk("R4 foreign read addr 0", v, 16'hFFFF);
    rd(5'd31, 5'd2, v); chk("R4 foreign read addr 31", v, 16'hFFFF);
    wr(5'd0, 5'd0, 16'h0000); rd(ME, 5'd0, v); chk("R4 foreign control write", v, 16'h3100);
    wr(5'd31, 5'd4, 16'h0000); rd(ME, 5'd4, v); chk("R4 foreign advert write", v, 16'h01E1);
  endtask

  task automatic t_read_timing;
    @(negedge clk);
    acc_addr = ME; acc_reg = 5'd4; wr_data = 16'h0021; wr_en = 1'b1; rd_en = 1'b1;
    #1 chk("R11 same-cycle read old", rd_data, 16'h01E1);
    @(negedge clk);
    wr_en = 1'b0;
    #1 chk("R11 read after write new", rd_data, 16'h0021);
    rd_en = 1'b0;
    #1 chk("R11 idle read zero", rd_data, 16'h0000);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_values();
    t_link();
    t_writable();
    t_soft_reset();
    t_read_only();
    t_unmapped();
    t_foreign();
    t_read_timing();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule